// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small fully associative table of segment descriptors for a 64-bit address translation path. Each entry pairs a segment-identifier word with a valid bit and a descriptor word. The descriptor word carries the segment size, a class bit, protection keys, a no-execute bit and a page-size code. A combinational lookup port resolves an effective address to the first matching entry. It matches a 256 MB segment and a 1 TB segment at the same time.

A single-issue command port handles the maintenance operations, and every command completes on the next clock edge:
- checked indexed write;
- indexed read of either word;
- invalidate-by-address in a local or global flavour;
- bulk invalidate steered by a 3-bit hint.

The block reports a rejected command on an error pulse. It raises a lookaside-flush pulse, local or global, for the downstream translation cache, so that the cache drops stale copies.

The command port has no back-pressure. A command is taken on every clock edge where `cmd_valid` is high. Its result pulses (`rd_valid`, `cmd_err`, `flush_loc`, `flush_glb`) are valid for exactly the one cycle after that edge.

Top module: `segtbl_cam`

## Requirements
- R1: A lookup hits an entry whose identifier word equals address bits 63:28 followed by a set valid bit 27 and zeros in bits 26:0, when that entry's size field (descriptor bits 63:62) is 00 (256 MB). In the same cycle `lk_hit` is 1, `lk_idx` gives the entry and `lk_vsid` gives its descriptor word.
- R2: A lookup also hits an entry whose identifier word equals address bits 63:40, then zeros in bits 39:28, then valid bit 27, when the size field is 01 (1 TB).
- R3: When several entries hit, the lowest index is reported.
- R4: On a miss, `lk_hit` is 0 and `lk_vsid` is all ones. When `mode64` is 0, address bits 63:32 are treated as zero before matching.
- R5: A write command (op 0) takes the slot from `cmd_rb[11:0]` and the identifier word from `cmd_rb[63:12]` with bits 11:0 zeroed. It stores `cmd_rs` as the descriptor. Read ops 1 (identifier word) and 2 (descriptor word) return the slot's word on `rd_data` with `rd_valid` one cycle later.
- R6: A write is rejected, with `cmd_err` pulsed and the table left unchanged, in four cases:
  - the slot is at or beyond DEPTH;
  - any identifier bit 26:12 is set;
  - descriptor bit 63 is set;
  - the size field is 01 while `seg1t_en` is 0.
- R7: A write is rejected when its page-size code {descriptor bit 8, bits 5:4} is not in the supported list. The default list is 000, 101 and 100.
- R8: A read of a slot at or beyond DEPTH pulses `cmd_err` and gives no `rd_valid`.
- R9: Invalidate-by-address (op 3 local, op 4 global) matches `cmd_rb` as in R1 to R3, without the `mode64` masking, and clears the valid bit of the hit entry. It pulses `flush_loc` (op 3) or `flush_glb` (op 4) only on a hit.
- R10: Bulk invalidate (op 5) always pulses `flush_loc`. With `mode_v3` at 0 every hint, and with `mode_v3` at 1 hints 0, 1, 2, 5 and 6, clear every valid entry except entry 0.
- R11: With `mode_v3` at 1, hints 3 and 4 include entry 0. Hint 3 leaves entries whose class bit (descriptor bit 7) is 0 untouched.
- R12: With `mode_v3` at 1, hint 7 clears no entry but still pulses `flush_loc`.
- R13: After reset every word of the table is zero, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_v3 | input | 1 | Selects the newest bulk-invalidate hint semantics |
| seg1t_en | input | 1 | Permits 1 TB segment writes |
| mode64 | input | 1 | 64-bit addressing for the lookup port |
| lk_addr | input | 64 | Lookup effective address |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | $clog2(DEPTH) | Index of the winning entry |
| lk_vsid | output | 64 | Descriptor of the winning entry, all ones on miss |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 write, 1 read id, 2 read descriptor, 3 inv local, 4 inv global, 5 bulk |
| cmd_rb | input | 64 | Slot/identifier or address operand |
| cmd_rs | input | 64 | Descriptor operand for writes |
| cmd_hint | input | 3 | Bulk-invalidate hint |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 64 | Read data |
| cmd_err | output | 1 | Rejected command pulse |
| flush_loc | output | 1 | Local lookaside flush request pulse |
| flush_glb | output | 1 | Global lookaside flush request pulse |

## Verification
The hardest situations to reach are overlapping hits and the class-filtered bulk clear. In the first, a 1 TB entry in a low slot shadows a 256 MB entry for the same addresses in a higher slot. In the second, entry 0 takes part in the clear. The bench writes a 1 TB entry below a 256 MB entry inside its range, and a duplicate 256 MB identifier into two slots. Before every one of the sixteen mode and hint combinations, it refills the whole table with alternating class bits and valid entry 0. It then reads back every slot to compare the surviving valid bits.

// File: rtl/segtbl_pkg.sv
package segtbl_pkg;
  typedef enum logic [2:0] {
    OP_WRITE   = 3'd0,
    OP_RD_ESID = 3'd1,
    OP_RD_VSID = 3'd2,
    OP_INV_LOC = 3'd3,
    OP_INV_GLB = 3'd4,
    OP_INV_ALL = 3'd5
  } seg_op_e;

  localparam int VBIT     = 27;  // valid bit in identifier word
  localparam int SEG_LO   = 28;  // low bit of 256 MB segment id
  localparam int SEG1T_LO = 40;  // low bit of 1 TB segment id
  localparam int RSV_HI   = 26;
  localparam int RSV_LO   = 12;
  localparam int CLS_BIT  = 7;
  localparam logic [1:0] SZ_256M = 2'b00;
  localparam logic [1:0] SZ_1T   = 2'b01;
endpackage

// File: rtl/segtbl_match.sv
module segtbl_match
  import segtbl_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][63:0] esid,
  input  logic [DEPTH-1:0][1:0]  size,
  input  logic [63-SEG_LO:0]     seg,
  output logic                   hit,
  output logic [IW-1:0]          idx
);
  localparam int SW = 64 - SEG_LO;
  localparam int TW = 64 - SEG1T_LO;

  logic [63:0] key256, key1t;
  logic [DEPTH-1:0] m;

  assign key256 = {seg, 1'b1, {VBIT{1'b0}}};
  assign key1t  = {seg[SW-1 -: TW], {(SEG1T_LO-SEG_LO){1'b0}}, 1'b1, {VBIT{1'b0}}};

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign m[i] = ((esid[i] == key256) && (size[i] == SZ_256M)) ||
                  ((esid[i] == key1t)  && (size[i] == SZ_1T));
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (m[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/segtbl_wchk.sv
module segtbl_wchk
  import segtbl_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int NPSZ = 3,
  parameter logic [NPSZ*3-1:0] PSZ_CODES = {3'b100, 3'b101, 3'b000}
) (
  input  logic [63:0] rb,
  input  logic [1:0]  size,
  input  logic [2:0]  pcode,
  input  logic        seg1t_en,
  output logic        slot_in,
  output logic        ok,
  output logic [63:0] esid
);
  logic [NPSZ-1:0] pmatch;
  logic rsv_bad, size_bad, no1t;

  for (genvar k = 0; k < NPSZ; k++) begin : g_psz
    assign pmatch[k] = (pcode == PSZ_CODES[k*3 +: 3]);
  end

  assign slot_in  = (rb[11:0] < 12'(DEPTH));
  assign esid     = {rb[63:12], 12'h000};
  assign rsv_bad  = |rb[RSV_HI:RSV_LO];
  assign size_bad = size[1];
  assign no1t     = (size == SZ_1T) && !seg1t_en;
  assign ok       = slot_in && !rsv_bad && !size_bad && !no1t && (|pmatch);
endmodule

// File: rtl/segtbl_bulk.sv
module segtbl_bulk #(
  parameter int DEPTH = 32
) (
  input  logic             v3,
  input  logic [2:0]       hint,
  input  logic [DEPTH-1:0] valid,
  input  logic [DEPTH-1:0] cls,
  output logic [DEPTH-1:0] clr
);
  logic incl0, none, cls_filter;

  assign incl0      = v3 && ((hint == 3'd3) || (hint == 3'd4));
  assign none       = v3 && (hint == 3'd7);
  assign cls_filter = v3 && (hint == 3'd3);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign clr[i] = valid[i] && incl0 && !none && !(cls_filter && !cls[i]);
    end else begin : g_rest
      assign clr[i] = valid[i] && !none && !(cls_filter && !cls[i]);
    end
  end
endmodule

// File: rtl/segtbl_cam.sv
module segtbl_cam
  import segtbl_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int NPSZ = 3,
  parameter logic [NPSZ*3-1:0] PSZ_CODES = {3'b100, 3'b101, 3'b000}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_v3,
  input  logic                     seg1t_en,
  input  logic                     mode64,
  input  logic [63:0]              lk_addr,
  output logic                     lk_hit,
  output logic [$clog2(DEPTH)-1:0] lk_idx,
  output logic [63:0]              lk_vsid,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [63:0]              cmd_rb,
  input  logic [63:0]              cmd_rs,
  input  logic [2:0]               cmd_hint,
  output logic                     rd_valid,
  output logic [63:0]              rd_data,
  output logic                     cmd_err,
  output logic                     flush_loc,
  output logic                     flush_glb
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0][63:0] esid_q, vsid_q;
  logic [DEPTH-1:0][1:0]  sz;
  logic [DEPTH-1:0]       vld, cls, clr;
  logic [63:0]            lk_eff, w_esid;
  logic                   inv_hit, w_ok, slot_in;
  logic [IW-1:0]          inv_idx, slot;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      sz[i]  = vsid_q[i][63:62];
      vld[i] = esid_q[i][VBIT];
      cls[i] = vsid_q[i][CLS_BIT];
    end
  end

  assign lk_eff = mode64 ? lk_addr : {32'h0, lk_addr[31:0]};
  assign slot   = cmd_rb[IW-1:0];

  segtbl_match #(.DEPTH(DEPTH)) u_lk (
    .esid(esid_q), .size(sz), .seg(lk_eff[63:SEG_LO]), .hit(lk_hit), .idx(lk_idx)
  );

  segtbl_match #(.DEPTH(DEPTH)) u_inv (
    .esid(esid_q), .size(sz), .seg(cmd_rb[63:SEG_LO]), .hit(inv_hit), .idx(inv_idx)
  );

  segtbl_wchk #(.DEPTH(DEPTH), .NPSZ(NPSZ), .PSZ_CODES(PSZ_CODES)) u_wchk (
    .rb(cmd_rb), .size(cmd_rs[63:62]), .pcode({cmd_rs[8], cmd_rs[5:4]}),
    .seg1t_en(seg1t_en), .slot_in(slot_in), .ok(w_ok), .esid(w_esid)
  );

  segtbl_bulk #(.DEPTH(DEPTH)) u_bulk (
    .v3(mode_v3), .hint(cmd_hint), .valid(vld), .cls(cls), .clr(clr)
  );

  assign lk_vsid = lk_hit ? vsid_q[lk_idx] : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      esid_q    <= '0;
      vsid_q    <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      cmd_err   <= 1'b0;
      flush_loc <= 1'b0;
      flush_glb <= 1'b0;
    end else begin
      rd_valid  <= 1'b0;
      cmd_err   <= 1'b0;
      flush_loc <= 1'b0;
      flush_glb <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_WRITE: begin
            if (w_ok) begin
              esid_q[slot] <= w_esid;
              vsid_q[slot] <= cmd_rs;
            end else begin
              cmd_err <= 1'b1;
            end
          end
          OP_RD_ESID, OP_RD_VSID: begin
            if (slot_in) begin
              rd_valid <= 1'b1;
              rd_data  <= (cmd_op == OP_RD_ESID) ? esid_q[slot] : vsid_q[slot];
            end else begin
              cmd_err <= 1'b1;
              rd_data <= '0;
            end
          end
          OP_INV_LOC, OP_INV_GLB: begin
            if (inv_hit) begin
              esid_q[inv_idx][VBIT] <= 1'b0;
              flush_loc <= (cmd_op == OP_INV_LOC);
              flush_glb <= (cmd_op == OP_INV_GLB);
            end
          end
          OP_INV_ALL: begin
            for (int i = 0; i < DEPTH; i++) begin
              if (clr[i]) esid_q[i][VBIT] <= 1'b0;
            end
            flush_loc <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_hit_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> esid_q[lk_idx][VBIT]);

  assert_hit_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !lk_vsid[63]);

  assert_err_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid));

  assert_flush_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_loc && flush_glb));

  assert_inv_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_INV_LOC || cmd_op == OP_INV_GLB) && !inv_hit)
      |=> !(flush_loc || flush_glb));

  assert_bulk_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_INV_ALL) |=> flush_loc);

  assert_keep0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_INV_ALL && !(mode_v3 && (cmd_hint == 3'd3 || cmd_hint == 3'd4)))
      |=> $stable(esid_q[0][VBIT]));
endmodule

// File: tb/segtbl_cam_bench.sv
`timescale 1ns/1ps
module segtbl_cam_bench;
  localparam int DEPTH = 32;
  localparam logic [63:0] VB = 64'h0000_0000_0800_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, mode_v3, seg1t_en, mode64;
  logic [63:0] lk_addr, lk_vsid, cmd_rb, cmd_rs, rd_data;
  logic lk_hit, cmd_valid, rd_valid, cmd_err, flush_loc, flush_glb;
  logic [4:0] lk_idx;
  logic [2:0] cmd_op, cmd_hint;

  segtbl_cam u_segtbl_cam (
    .clk(clk), .rst_n(rst_n), .mode_v3(mode_v3), .seg1t_en(seg1t_en), .mode64(mode64),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_vsid(lk_vsid),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rb(cmd_rb), .cmd_rs(cmd_rs),
    .cmd_hint(cmd_hint), .rd_valid(rd_valid), .rd_data(rd_data), .cmd_err(cmd_err),
    .flush_loc(flush_loc), .flush_glb(flush_glb)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] m_esid [DEPTH];
  logic [63:0] m_vsid [DEPTH];

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(logic [63:0] a);
    logic [63:0] e256 = {a[63:28], 28'h0} | VB;
    logic [63:0] e1t  = {a[63:40], 40'h0} | VB;
    for (int i = 0; i < DEPTH; i++)
      if ((m_esid[i] == e256 && m_vsid[i][63:62] == 2'b00) ||
          (m_esid[i] == e1t  && m_vsid[i][63:62] == 2'b01)) return i;
    return -1;
  endfunction

  task automatic chk_lk(logic [63:0] a, string req);
    logic [63:0] ea;
    int k;
    @(negedge clk);
    lk_addr = a;
    #1;
    ea = mode64 ? a : {32'h0, a[31:0]};
    k = m_find(ea);
    chk(lk_hit == (k >= 0), req, "lk_hit", 64'(lk_hit), 64'(k >= 0));
    if (k >= 0) begin
      chk(lk_idx == 5'(k), req, "lk_idx", 64'(lk_idx), 64'(k));
      chk(lk_vsid == m_vsid[k], req, "lk_vsid", lk_vsid, m_vsid[k]);
    end else begin
      chk(lk_vsid == '1, req, "lk_vsid miss", lk_vsid, '1);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [63:0] rb, logic [63:0] rs, logic [2:0] hint, string req);
    int slot = int'(rb[11:0]);
    bit in = slot < DEPTH;
    bit e_err = 0, e_rv = 0, e_fl = 0, e_fg = 0;
    logic [63:0] e_rd = '0;
    logic [2:0] pc = {rs[8], rs[5:4]};
    case (op)
      3'd0: begin
        if (in && rb[26:12] == 0 && !rs[63] && !(rs[62] && !seg1t_en) &&
            (pc == 3'b000 || pc == 3'b101 || pc == 3'b100)) begin
          m_esid[slot] = {rb[63:12], 12'h0};
          m_vsid[slot] = rs;
        end else e_err = 1;
      end
      3'd1, 3'd2: begin
        if (in) begin
          e_rv = 1;
          e_rd = (op == 3'd1) ? m_esid[slot] : m_vsid[slot];
        end else e_err = 1;
      end
      3'd3, 3'd4: begin
        int k = m_find(rb);
        if (k >= 0) begin
          m_esid[k][27] = 1'b0;
          e_fl = (op == 3'd3);
          e_fg = (op == 3'd4);
        end
      end
      3'd5: begin
        bit v3 = mode_v3;
        bit from0 = v3 && (hint == 3'd3 || hint == 3'd4);
        bit none = v3 && hint == 3'd7;
        e_fl = 1;
        for (int i = 0; i < DEPTH; i++)
          if (m_esid[i][27] && (i > 0 || from0) && !none && !(v3 && hint == 3'd3 && !m_vsid[i][7]))
            m_esid[i][27] = 1'b0;
      end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_rb = rb; cmd_rs = rs; cmd_hint = hint;
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_err == e_err, req, "cmd_err", 64'(cmd_err), 64'(e_err));
    chk(rd_valid == e_rv, req, "rd_valid", 64'(rd_valid), 64'(e_rv));
    if (e_rv) chk(rd_data == e_rd, req, "rd_data", rd_data, e_rd);
    chk(flush_loc == e_fl, req, "flush_loc", 64'(flush_loc), 64'(e_fl));
    chk(flush_glb == e_fg, req, "flush_glb", 64'(flush_glb), 64'(e_fg));
  endtask

  task automatic chk_table(string req);
    for (int i = 0; i < DEPTH; i++) begin
      issue(3'd1, 64'(i), '0, '0, req);
      issue(3'd2, 64'(i), '0, '0, req);
    end
  endtask

  task automatic fill(int base);
    for (int i = 0; i < DEPTH; i++) begin
      logic [63:0] rb = (64'(base + i) << 28) | VB | 64'(i);
      logic [63:0] rs = (64'(i) << 12) | (i[0] ? 64'h80 : 64'h0) |
                        ((i % 3 == 1) ? 64'h110 : (i % 3 == 2) ? 64'h100 : 64'h0);
      issue(3'd0, rb, rs, '0, "R5");
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_esid[i] = '0; m_vsid[i] = '0; end
    rst_n = 0; mode_v3 = 0; seg1t_en = 0; mode64 = 1; lk_addr = '0;
    cmd_valid = 0; cmd_op = '0; cmd_rb = '0; cmd_rs = '0; cmd_hint = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R13: empty table after reset
    chk_lk(64'h0, "R13");
    chk_lk(64'h0000_0001_0000_0000, "R13");
    chk_table("R13");

    // R5 / R1: fill and read back, hit every entry
    fill(1);
    chk_table("R5");
    for (int i = 0; i < DEPTH; i++)
      chk_lk((64'(1 + i) << 28) | 64'((i * 32'h123457) & 32'h0FFF_FFFF), "R1");

    // R4: misses
    chk_lk(64'h0, "R4");
    chk_lk(64'(33) << 28, "R4");

    // R6: rejected writes
    for (int s = 32; s < 36; s++) issue(3'd0, (64'h5 << 28) | VB | 64'(s), 64'h0, '0, "R6");
    issue(3'd0, (64'h5 << 28) | VB | 64'hFFF, 64'h0, '0, "R6");
    for (int b = 12; b <= 26; b++) issue(3'd0, (64'h5 << 28) | VB | (64'h1 << b) | 64'h3, 64'h0, '0, "R6");
    issue(3'd0, (64'h5 << 28) | VB | 64'h3, 64'h2 << 62, '0, "R6");
    issue(3'd0, (64'h5 << 28) | VB | 64'h3, 64'h3 << 62, '0, "R6");
    issue(3'd0, (64'h5 << 28) | VB | 64'h3, 64'h1 << 62, '0, "R6");
    // R7: page-size code sweep
    for (int c = 0; c < 8; c++)
      issue(3'd0, (64'h44 << 28) | VB | 64'h4, (64'(c >> 2) << 8) | (64'(c & 3) << 4) | 64'h700, '0, "R7");
    chk_table("R6");

    // R8: out-of-range reads
    issue(3'd1, 64'd40, '0, '0, "R8");
    issue(3'd2, 64'hFFF, '0, '0, "R8");

    // R2: 1 TB entries
    seg1t_en = 1;
    issue(3'd0, (64'hABCDEF << 40) | VB | 64'h5, (64'h1 << 62) | 64'h80 | 64'h3000, '0, "R2");
    chk_lk({24'hABCDEF, 40'h12_3456_789A}, "R2");
    chk_lk({24'hABCDEF, 40'hFF_FFFF_FFFF}, "R2");
    issue(3'd0, (64'h1234 << 40) | (64'h1 << 30) | VB | 64'h6, 64'h1 << 62, '0, "R2");
    chk_lk((64'h1234 << 40) | (64'h1 << 30), "R2");

    // R3: priority
    issue(3'd0, (64'h77 << 28) | VB | 64'd9, 64'h9999_0000, '0, "R3");
    issue(3'd0, (64'h77 << 28) | VB | 64'd20, 64'h2020_0000, '0, "R3");
    chk_lk((64'h77 << 28) | 64'h55, "R3");
    issue(3'd0, (64'hABCDEF << 40) | (64'h3 << 28) | VB | 64'd7, 64'h7777_0000, '0, "R3");
    chk_lk((64'hABCDEF << 40) | (64'h3 << 28) | 64'h1, "R3");

    // R4: 32-bit addressing
    issue(3'd0, (64'h3 << 28) | VB | 64'd11, 64'h1111_0000, '0, "R4");
    mode64 = 0;
    chk_lk(64'hFFFF_FFFF_3000_0010, "R4");
    mode64 = 1;
    chk_lk(64'hFFFF_FFFF_3000_0010, "R4");

    // R9: invalidate by address
    issue(3'd3, (64'h77 << 28) | 64'h99, '0, '0, "R9");
    chk_lk(64'h77 << 28, "R9");
    issue(3'd4, (64'h77 << 28) | 64'h99, '0, '0, "R9");
    chk_lk(64'h77 << 28, "R9");
    issue(3'd3, (64'h77 << 28) | 64'h99, '0, '0, "R9");
    issue(3'd4, (64'h77 << 28) | 64'h99, '0, '0, "R9");

    // R10 / R11 / R12: bulk invalidate sweep
    for (int v = 0; v < 2; v++) begin
      for (int h = 0; h < 8; h++) begin
        string req;
        mode_v3 = v[0];
        req = (v == 1 && h == 7) ? "R12" : (v == 1 && (h == 3 || h == 4)) ? "R11" : "R10";
        fill(1 + h);
        issue(3'd5, '0, '0, 3'(h), req);
        chk_table(req);
        chk_lk(64'(1 + h) << 28, req);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule